// File: doc/BRIEF.md
# Registered Command Fanout Buffer with Pipelined Parity Check

This block registers a 14-bit command/address word on the rising clock edge and drives two identical registered copies of it, so that one input load can feed two output nets. Alongside the data path it runs a parity check. The incoming word is split into two 7-bit groups. Each group has its own parity input bit from the controller, its own partial-parity output and its own active-low error flag. The parity results are pipelined, so they come out two cycles after the data word they describe.

Two buffers can be chained to check a wider word. A configuration input marks the buffer as either standalone/first (low) or second (high). A second buffer takes the partial-parity outputs of the first on its cascade inputs. It folds them into its own result and presents the final error one cycle later than a standalone buffer would.

Two chip-select inputs save power:
- A high primary select holds the data copies.
- With both selects high, the data copies, the parity pipeline and its outputs all freeze.

An asynchronous reset clears everything at once. A small state machine releases the reset in step with the clock. Its states are:
- `ST_RST`: held while reset is low.
- `ST_SYNC`: one clock edge of settling.
- `ST_RUN`: normal operation.

Its transitions are:
- `ST_RST` → `ST_SYNC` on the first edge with reset high.
- `ST_SYNC` → `ST_RUN` on the next edge.
- Any state → `ST_RST` at once when reset goes low.

Within `ST_RUN`, the chip selects decode to one of three modes each cycle:
- `MODE_LIVE`: primary select low.
- `MODE_QHOLD`: primary select high, secondary select low.
- `MODE_SLEEP`: both selects high.

Top module: `cmd_fanout_buf`

## Requirements
- R1: On each rising edge in `ST_RUN` with `cs_a` low, both `q_a` and `q_b` take the value of `d_in`.
- R2: While `rst_n` is low, `q_a`, `q_b` and `ppo` are 0 and `err_n` is 2'b11. This takes effect at once, without waiting for a clock edge.
- R3: After `rst_n` rises, the first two rising edges change nothing. The third rising edge is the first capture.
- R4: Group g (g = 0, 1) covers `d_in[7g+6:7g]` and uses `par_in[g]`. Its partial parity is the XOR of those 7 bits and `par_in[g]`, so a result of 1 means a parity error under even parity.
- R5: With `cfg_second` low, the partial parity of a word captured at advancing edge k appears on `ppo[g]` after advancing edge k+2. At the same edge, `err_n[g]` becomes the inverse of that partial parity. The error is therefore low for exactly one advancing cycle per bad word.
- R6: With `cfg_second` high, `ppo[g]` keeps the R5 timing. After advancing edge k+3, `err_n[g]` equals NOT(partial parity of word k XOR `casc_in[g]`), where `casc_in[g]` is sampled at edge k+3.
- R7: An edge with `cs_a` high leaves `q_a` and `q_b` unchanged. If `cs_b` is low, the parity pipeline still advances.
- R8: An edge with both `cs_a` and `cs_b` high changes none of `q_a`, `q_b`, `ppo` and `err_n`, and no word enters the parity pipeline.
- R9: A low `rst_n` overrides the chip selects: the R2 values appear even while both selects are high.
- R10: `q_a` and `q_b` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through the state machine |
| d_in | input | 14 | Command/address word |
| par_in | input | 2 | Controller parity bit per group |
| cfg_second | input | 1 | 0: standalone or first of a pair; 1: second of a pair |
| cs_a | input | 1 | Primary chip select; high holds the data copies |
| cs_b | input | 1 | Secondary chip select; high together with `cs_a` freezes everything |
| casc_in | input | 2 | Partial-parity bits from the first buffer of a pair |
| q_a | output | 14 | Registered data, copy A |
| q_b | output | 14 | Registered data, copy B |
| ppo | output | 2 | Partial-parity output per group |
| err_n | output | 2 | Active-low parity error per group |

## Verification
The bench drives all ones on the data during the two settling edges after reset release. A design that let reset go free straight away would show the word one or two cycles early.

It also sends a single bad word between good ones and checks that the error is low in exactly one cycle, two edges after the capture. A pipeline that is one stage short or long would flag the wrong cycle, and a sticky flag would stay low.

Random runs mix the select patterns. They show whether an implementation wrongly freezes the parity pipeline on a primary-only hold, or keeps advancing it during sleep.

Reset is also asserted between edges with both selects high, and the outputs are checked before the next edge. A design that gated reset behind the selects, or took reset synchronously, would still show the old values. The second-device mode runs with random cascade bits, which exposes an error computed one cycle early or without the cascade input.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

    typedef enum logic [1:0] {
        ST_RST  = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } rel_state_e;

    typedef enum logic [1:0] {
        MODE_LIVE  = 2'd0,
        MODE_QHOLD = 2'd1,
        MODE_SLEEP = 2'd2
    } gate_mode_e;

endpackage

// File: rtl/cfb_release_fsm.sv
module cfb_release_fsm
    import cfb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic run
);

    rel_state_e state_q;
    rel_state_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST:  state_d = ST_SYNC;
            ST_SYNC: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_RST;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RST;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_RST:  run = 1'b0;
            ST_SYNC: run = 1'b0;
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    AST_NO_EARLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RST) |=> (state_q == ST_SYNC)); // R3

    AST_RUN_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ($past(state_q) != ST_RST)); // R3

endmodule

// File: rtl/cfb_gate_ctl.sv
module cfb_gate_ctl
    import cfb_pkg::*;
(
    input  logic run,
    input  logic cs_a,
    input  logic cs_b,
    output logic load_q,
    output logic adv_par
);

    gate_mode_e mode;

    // decode the chip-select pair
    always_comb begin
        if (!cs_a)     mode = MODE_LIVE;
        else if (!cs_b) mode = MODE_QHOLD;
        else           mode = MODE_SLEEP;
    end

    always_comb begin
        load_q  = 1'b0;
        adv_par = 1'b0;
        unique case (mode)
            MODE_LIVE: begin
                load_q  = run;
                adv_par = run;
            end
            MODE_QHOLD: begin
                load_q  = 1'b0;
                adv_par = run;
            end
            MODE_SLEEP: begin
                load_q  = 1'b0;
                adv_par = 1'b0;
            end
            default: begin
                load_q  = 1'b0;
                adv_par = 1'b0;
            end
        endcase
    end

    always_comb begin
        if (load_q) assert (adv_par) else $error("AST_LOAD_IMPLIES_ADV"); // R8
    end

endmodule

// File: rtl/cfb_fanout_reg.sv
module cfb_fanout_reg #(
    parameter int W      = 14,
    parameter int COPIES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [W-1:0]              d,
    output logic [COPIES-1:0][W-1:0]  q
);

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q[c] <= '0;
            else if (load) q[c] <= d;
        end
    end

endmodule

// File: rtl/cfb_parity_lane.sv
module cfb_parity_lane #(
    parameter int GW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          second,
    input  logic [GW-1:0] d_grp,
    input  logic          par_bit,
    input  logic          casc_bit,
    output logic          ppo,
    output logic          err_n
);

    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1    <= 1'b0;
            s2    <= 1'b0;
            s3    <= 1'b0;
            ppo   <= 1'b0;
            err_n <= 1'b1;
        end else if (adv) begin
            s1    <= (^d_grp) ^ par_bit;
            s2    <= s1;
            s3    <= s2;
            ppo   <= s2;
            err_n <= second ? ~(s3 ^ casc_bit) : ~s2;
        end
    end

    AST_LANE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(ppo) && $stable(err_n))); // R8

    AST_ALONE_ERR_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !second) |=> (err_n == !ppo)); // R5

endmodule

// File: rtl/cmd_fanout_buf.sv
module cmd_fanout_buf #(
    parameter int DATA_W = 14,
    parameter int N_GRP  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_in,
    input  logic [N_GRP-1:0]  par_in,
    input  logic              cfg_second,
    input  logic              cs_a,
    input  logic              cs_b,
    input  logic [N_GRP-1:0]  casc_in,
    output logic [DATA_W-1:0] q_a,
    output logic [DATA_W-1:0] q_b,
    output logic [N_GRP-1:0]  ppo,
    output logic [N_GRP-1:0]  err_n
);

    localparam int GRP_W  = DATA_W / N_GRP;
    localparam int COPIES = 2;

    logic run, load_q, adv_par;
    logic [COPIES-1:0][DATA_W-1:0] q_copies;

    cfb_release_fsm u_rel (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run)
    );

    cfb_gate_ctl u_gate (
        .run     (run),
        .cs_a    (cs_a),
        .cs_b    (cs_b),
        .load_q  (load_q),
        .adv_par (adv_par)
    );

    cfb_fanout_reg #(.W(DATA_W), .COPIES(COPIES)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_q),
        .d     (d_in),
        .q     (q_copies)
    );

    assign q_a = q_copies[0];
    assign q_b = q_copies[1];

    for (genvar g = 0; g < N_GRP; g++) begin : g_lane
        cfb_parity_lane #(.GW(GRP_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv      (adv_par),
            .second   (cfg_second),
            .d_grp    (d_in[g*GRP_W +: GRP_W]),
            .par_bit  (par_in[g]),
            .casc_bit (casc_in[g]),
            .ppo      (ppo[g]),
            .err_n    (err_n[g])
        );
    end

    AST_COPIES_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        q_a == q_b); // R10

    AST_QHOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_a |=> ($stable(q_a) && $stable(q_b))); // R7

    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_a && cs_b) |=> ($stable(ppo) && $stable(err_n) && $stable(q_a))); // R8

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (q_a == '0 && ppo == '0 && err_n == '1)); // R9

endmodule

// File: tb/sim_cmd_fanout_buf.sv
module sim_cmd_fanout_buf;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [13:0] d_in;
    logic [1:0]  par_in;
    logic        cfg_second;
    logic        cs_a, cs_b;
    logic [1:0]  casc_in;
    logic [13:0] q_a, q_b;
    logic [1:0]  ppo, err_n;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    cmd_fanout_buf u0 (
        .clk(clk), .rst_n(rst_n), .d_in(d_in), .par_in(par_in),
        .cfg_second(cfg_second), .cs_a(cs_a), .cs_b(cs_b), .casc_in(casc_in),
        .q_a(q_a), .q_b(q_b), .ppo(ppo), .err_n(err_n)
    );

    // behavioural reference
    logic [13:0] mq;
    logic [1:0]  mppo, merr;
    int          mcnt;
    bit          h0[$];
    bit          h1[$];

    function automatic bit grp_par(input logic [13:0] d, input logic p, input int g);
        bit r = p;
        for (int i = 0; i < 7; i++) r ^= d[g*7 + i];
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mq = '0; mppo = '0; merr = 2'b11; mcnt = 0;
            h0 = '{0, 0, 0, 0};
            h1 = '{0, 0, 0, 0};
        end else if (mcnt < 2) begin
            mcnt++;
        end else begin
            if (!cs_a) mq = d_in;
            if (!(cs_a && cs_b)) begin
                h0.push_front(grp_par(d_in, par_in[0], 0));
                h1.push_front(grp_par(d_in, par_in[1], 1));
                mppo[0] = h0[2];
                mppo[1] = h1[2];
                merr[0] = cfg_second ? ~(h0[3] ^ casc_in[0]) : ~h0[2];
                merr[1] = cfg_second ? ~(h1[3] ^ casc_in[1]) : ~h1[2];
                void'(h0.pop_back());
                void'(h1.pop_back());
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    bit model_on = 1'b0;

    always @(posedge clk) begin
        #5;
        if (model_on) begin
            chk(q_a == mq, "R1", "q_a", 32'(q_a), 32'(mq));
            chk(q_b == mq, "R10", "q_b", 32'(q_b), 32'(mq));
            chk(ppo == mppo, cfg_second ? "R6" : "R5", "ppo", 32'(ppo), 32'(mppo));
            chk(err_n == merr, cfg_second ? "R6" : "R5", "err_n", 32'(err_n), 32'(merr));
        end
    end

    task automatic step(input logic [13:0] d, input logic [1:0] p,
                        input logic a, input logic b, input logic [1:0] c);
        @(negedge clk);
        d_in = d; par_in = p; cs_a = a; cs_b = b; casc_in = c;
    endtask

    task automatic rand_run(input int n, input int hold_pct);
        for (int i = 0; i < n; i++) begin
            step(14'($urandom), 2'($urandom), ($urandom % 100) < hold_pct,
                 1'($urandom), 2'($urandom));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit seen [5];
        rst_n = 1'b1; d_in = '0; par_in = '0; cfg_second = 1'b0;
        cs_a = 1'b0; cs_b = 1'b0; casc_in = '0;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        // R2: reset state
        chk(q_a == 0 && q_b == 0, "R2", "q during reset", 32'(q_a), 0);
        chk(ppo == 0 && err_n == 2'b11, "R2", "ppo/err_n during reset",
            32'({ppo, err_n}), 32'b0011);

        // R3: two settling edges ignore data
        @(negedge clk);
        d_in = '1;
        #3 rst_n = 1'b1;
        @(posedge clk); #5;
        chk(q_a == 0, "R3", "q after edge 1", 32'(q_a), 0);
        @(posedge clk); #5;
        chk(q_a == 0, "R3", "q after edge 2", 32'(q_a), 0);
        @(posedge clk); #5;
        chk(q_a == 14'h3fff, "R3", "q after edge 3", 32'(q_a), 32'h3fff);

        model_on = 1'b1;
        rand_run(200, 0);   // R1 R4 R5
        rand_run(300, 40);  // R7 R8

        // R5: single bad word gives one low error cycle two edges later
        repeat (4) step(14'h0000, 2'b00, 1'b0, 1'b0, 2'b00);
        step(14'h0001, 2'b00, 1'b0, 1'b0, 2'b00);
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #5;
            seen[i] = !err_n[0];
            @(negedge clk);
            d_in = '0; par_in = '0;
        end
        for (int i = 0; i < 5; i++)
            chk(seen[i] == (i == 2), "R5", "err_n[0] low pulse",
                32'(seen[i]), 32'(i == 2));

        // R9: reset overrides chip selects, asynchronously
        @(negedge clk);
        cs_a = 1'b1; cs_b = 1'b1;
        #4 rst_n = 1'b0;
        #1;
        chk(q_a == 0 && q_b == 0, "R9", "q under reset+sleep", 32'(q_a), 0);
        chk(err_n == 2'b11 && ppo == 0, "R9", "parity outs under reset+sleep",
            32'({ppo, err_n}), 32'b0011);
        cfg_second = 1'b1;
        repeat (3) @(negedge clk);
        cs_a = 1'b0; cs_b = 1'b0;
        #3 rst_n = 1'b1;

        rand_run(300, 0);   // R6
        rand_run(200, 30);  // R6 with R7/R8 gating

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule